// File: doc/BRIEF.md
# Parallel DAC Write Sequencer

This block sits on the host side of a 12-bit parallel multiplying DAC whose input latch is transparent while its active-low select and write strobes are both low. The block takes one sample at a time on a valid/ready handshake. It converts the sample to the code the converter expects, then plays out one complete write cycle on the data bus and the two strobes.

Each write follows a slow, glitch-free order. The bus is driven first and settles before the latch opens. Select comes before write. The write strobe is held for its minimum width, and the strobes close with write first and select second. The bus then stays put for a hold window before the next sample may be taken.

A mode input picks plain unipolar binary or two's-complement bipolar data; bipolar samples are turned into offset binary by flipping the top bit. A supply-select input picks one of two timing sets. Both sets are given in nanoseconds and rounded up to clock cycles at elaboration.

Top module: `dac_write_seq`

## Requirements
- R1: After reset, cs_n and wr_n are high, the bus is zero, s_ready is high and busy is low, and no write strobe occurs while no sample has been accepted.
- R2: A sample is taken on a clock edge with s_valid and s_ready both high. From the next cycle until the write cycle ends, s_ready is low and busy is high. A sample held on s_valid during that time is stalled and written afterwards, not dropped. bipolar and hi_supply are captured together with the sample.
- R3: With bipolar low, the bus carries the sample unchanged, with bit 11 as the MSB and bit 0 as the LSB.
- R4: With bipolar high, the bus carries the sample with only bit 11 inverted, so 0x7FF gives 0xFFF and 0x800 gives 0x000.
- R5: The bus is driven at least PRE_CYC cycles before cs_n falls. wr_n is never low while cs_n is high. cs_n rises only after wr_n is already high.
- R6: wr_n stays low for exactly ceil(WR_NS/CLK_NS) cycles: 100 cycles with hi_supply low and 60 cycles with it high, at the default values.
- R7: cs_n is low for at least ceil(CS_NS/CLK_NS) cycles before wr_n rises: 95 cycles with hi_supply low, 50 with it high.
- R8: The bus does not change while both strobes are low, and it is stable for at least ceil(DS_NS/CLK_NS) cycles before wr_n rises: 53 cycles with hi_supply low, 30 with it high.
- R9: After wr_n rises, the bus stays unchanged and s_ready stays low for at least ceil(DH_NS/CLK_NS) = 3 cycles.
- R10: A transparent latch that follows the bus while both strobes are low ends each write holding the expected code for that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Sequencer idle and able to take a sample |
| s_data | input | 12 | Sample value |
| bipolar | input | 1 | 1: two's-complement sample, 0: unipolar binary |
| hi_supply | input | 1 | 1: high-supply timing set, 0: low-supply timing set |
| dac_db | output | 12 | Parallel data bus to the converter |
| dac_cs_n | output | 1 | Active-low chip select |
| dac_wr_n | output | 1 | Active-low write strobe |
| busy | output | 1 | Write cycle in progress |

## Verification
A corrupted state or interval count shows up directly as a wrong strobe width or a wrong select lead, measured on the first write after the fault. A skipped state shows as an ordering break between cs_n, wr_n and the bus in the same cycle it happens. A wrong code path or a mode captured at the wrong time leaves the latch model holding a bad value when that write ends. A lost stall shows as a missing write once the stalled sample should have gone out, about 110 cycles later.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CSLEAD,
    ST_STROBE,
    ST_CSOFF,
    ST_HOLD
  } seq_state_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dac_code_fmt.sv
module dac_code_fmt #(
  parameter int DW = 12
) (
  input  logic          bipolar,
  input  logic [DW-1:0] raw,
  output logic [DW-1:0] code
);

  generate
    if (DW > 1) begin : g_wide
      assign code = {raw[DW-1] ^ bipolar, raw[DW-2:0]};
    end else begin : g_single
      assign code = raw ^ bipolar;
    end
  endgenerate

endmodule

// File: rtl/dac_seq_timer.sv
module dac_seq_timer #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val - CW'(1);
    end else if (remain != '0) begin
      remain <= remain - CW'(1);
    end
  end

  assign done = (remain == '0);

endmodule

// File: rtl/dac_seq_fsm.sv
module dac_seq_fsm
  import dac_seq_pkg::*;
#(
  parameter int DW       = 12,
  parameter int CW       = 7,
  parameter int PRE_C    = 2,
  parameter int CSL_LO   = 1,
  parameter int CSL_HI   = 1,
  parameter int WR_LO    = 100,
  parameter int WR_HI    = 60,
  parameter int HOLD_C   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] code_in,
  input  logic          hi_supply,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  input  logic          tmr_done,
  output logic [DW-1:0] dac_db,
  output logic          dac_cs_n,
  output logic          dac_wr_n,
  output logic          busy
);

  seq_state_t state;
  logic       hi_q;

  assign s_ready = (state == ST_IDLE);
  assign busy    = (state != ST_IDLE);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = CW'(PRE_C);
    case (state)
      ST_IDLE: begin
        tmr_load = s_valid;
        tmr_val  = CW'(PRE_C);
      end
      ST_SETUP: begin
        tmr_load = tmr_done;
        tmr_val  = hi_q ? CW'(CSL_HI) : CW'(CSL_LO);
      end
      ST_CSLEAD: begin
        tmr_load = tmr_done;
        tmr_val  = hi_q ? CW'(WR_HI) : CW'(WR_LO);
      end
      ST_CSOFF: begin
        tmr_load = 1'b1;
        tmr_val  = CW'(HOLD_C);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      dac_db   <= '0;
      dac_cs_n <= 1'b1;
      dac_wr_n <= 1'b1;
      hi_q     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (s_valid) begin
          dac_db <= code_in;
          hi_q   <= hi_supply;
          state  <= ST_SETUP;
        end
        ST_SETUP: if (tmr_done) begin
          dac_cs_n <= 1'b0;
          state    <= ST_CSLEAD;
        end
        ST_CSLEAD: if (tmr_done) begin
          dac_wr_n <= 1'b0;
          state    <= ST_STROBE;
        end
        ST_STROBE: if (tmr_done) begin
          dac_wr_n <= 1'b1;
          state    <= ST_CSOFF;
        end
        ST_CSOFF: begin
          dac_cs_n <= 1'b1;
          state    <= ST_HOLD;
        end
        ST_HOLD: if (tmr_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Strobe-width counter used only by the width check below.
  logic [CW-1:0] wr_run;
  always_ff @(posedge clk) begin
    if (rst)            wr_run <= '0;
    else if (!dac_wr_n) wr_run <= wr_run + CW'(1);
    else                wr_run <= '0;
  end

  p_wr_inside_cs_r5: assert property (@(posedge clk) disable iff (rst)
    !dac_wr_n |-> !dac_cs_n);

  p_cs_after_wr_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_cs_n) |-> $past(dac_wr_n));

  p_bus_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (!dac_cs_n && !dac_wr_n) |=> $stable(dac_db));

  p_stall_after_take_r2: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> (!s_ready && busy));

  p_bus_moves_on_take_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_db) |-> $past(s_valid && s_ready));

  p_wr_width_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_wr_n) |-> (wr_run == (hi_q ? CW'(WR_HI) : CW'(WR_LO))));

endmodule

// File: rtl/dac_write_seq.sv
module dac_write_seq
  import dac_seq_pkg::*;
#(
  parameter int DW        = 12,
  parameter int CLK_NS    = 4,
  parameter int PRE_CYC   = 2,
  parameter int WR_NS_LO  = 400,
  parameter int WR_NS_HI  = 240,
  parameter int CS_NS_LO  = 380,
  parameter int CS_NS_HI  = 200,
  parameter int DS_NS_LO  = 210,
  parameter int DS_NS_HI  = 120,
  parameter int DH_NS     = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic          bipolar,
  input  logic          hi_supply,
  output logic [DW-1:0] dac_db,
  output logic          dac_cs_n,
  output logic          dac_wr_n,
  output logic          busy
);

  localparam int WR_LO  = at_least_one(ceil_div(WR_NS_LO, CLK_NS));
  localparam int WR_HI  = at_least_one(ceil_div(WR_NS_HI, CLK_NS));
  localparam int CSL_LO = at_least_one(ceil_div(CS_NS_LO, CLK_NS) - WR_LO);
  localparam int CSL_HI = at_least_one(ceil_div(CS_NS_HI, CLK_NS) - WR_HI);
  localparam int PRE_LO = ceil_div(DS_NS_LO, CLK_NS) - CSL_LO - WR_LO;
  localparam int PRE_HI = ceil_div(DS_NS_HI, CLK_NS) - CSL_HI - WR_HI;
  localparam int PRE_C  = at_least_one(imax(PRE_CYC, imax(PRE_LO, PRE_HI)));
  localparam int HOLD_C = at_least_one(ceil_div(DH_NS, CLK_NS));
  localparam int MAX_C  = imax(imax(WR_LO, WR_HI),
                               imax(imax(CSL_LO, CSL_HI), imax(PRE_C, HOLD_C)));
  localparam int CW     = $clog2(MAX_C + 1);

  logic [DW-1:0] code;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_done;

  dac_code_fmt #(.DW(DW)) u_fmt (
    .bipolar (bipolar),
    .raw     (s_data),
    .code    (code)
  );

  dac_seq_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  dac_seq_fsm #(
    .DW(DW), .CW(CW), .PRE_C(PRE_C), .CSL_LO(CSL_LO), .CSL_HI(CSL_HI),
    .WR_LO(WR_LO), .WR_HI(WR_HI), .HOLD_C(HOLD_C)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .code_in   (code),
    .hi_supply (hi_supply),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .tmr_done  (tmr_done),
    .dac_db    (dac_db),
    .dac_cs_n  (dac_cs_n),
    .dac_wr_n  (dac_wr_n),
    .busy      (busy)
  );

  p_ready_vs_busy_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(s_valid && s_ready));

  p_cs_quiet_idle_r1: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> (dac_cs_n && dac_wr_n));

endmodule

// File: tb/tb_dac_write_seq.sv
module tb_dac_write_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [11:0] s_data = '0;
  logic        bipolar = 1'b0;
  logic        hi_supply = 1'b0;
  logic [11:0] dac_db;
  logic        dac_cs_n, dac_wr_n, busy;

  always #2 clk = ~clk;

  dac_write_seq dut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .bipolar(bipolar), .hi_supply(hi_supply),
    .dac_db(dac_db), .dac_cs_n(dac_cs_n), .dac_wr_n(dac_wr_n), .busy(busy)
  );

  int compared = 0;
  int mismatched = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural latch model and timing monitor, sampled at the falling edge.
  logic [11:0] latch_q = '0, prev_db = '0, hold_db = '0;
  logic        prev_wr = 1'b1, prev_cs = 1'b1, prev_both = 1'b0, in_hold = 1'b0;
  int wr_run = 0, cs_run = 0, db_stab = 0, hold_cnt = 0;
  int last_wr = 0, last_cs = 0, last_ds = 0, last_hold = 0, last_pre = 0;
  int writes = 0, order_err = 0, glitch_err = 0, hold_err = 0, busy_err = 0;

  always @(negedge clk) begin
    if (rst) begin
      prev_wr = 1'b1; prev_cs = 1'b1; prev_both = 1'b0; in_hold = 1'b0;
      wr_run = 0; cs_run = 0; db_stab = 0; prev_db = dac_db;
    end else begin
      db_stab = (dac_db == prev_db) ? db_stab + 1 : 1;
      if (!dac_wr_n && dac_cs_n) order_err++;
      if (dac_cs_n && !prev_cs && !prev_wr) order_err++;
      if (!dac_cs_n && (s_ready || !busy)) busy_err++;
      if (!dac_cs_n && prev_cs) last_pre = db_stab;
      if (!dac_cs_n && !dac_wr_n) begin
        if (prev_both && dac_db != prev_db) glitch_err++;
        latch_q = dac_db;
      end
      if (in_hold) begin
        if (dac_db != hold_db) hold_err++;
        if (s_ready) begin last_hold = hold_cnt; in_hold = 1'b0; end
        else hold_cnt++;
      end
      if (dac_wr_n && !prev_wr) begin
        last_wr = wr_run; last_cs = cs_run; last_ds = db_stab;
        writes++; in_hold = 1'b1; hold_cnt = 1; hold_db = dac_db;
      end
      wr_run = !dac_wr_n ? wr_run + 1 : 0;
      cs_run = !dac_cs_n ? cs_run + 1 : 0;
      prev_both = !dac_cs_n && !dac_wr_n;
      prev_wr = dac_wr_n; prev_cs = dac_cs_n; prev_db = dac_db;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic send(input logic [11:0] d, input logic b, input logic h);
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1; s_data = d; bipolar = b; hi_supply = h;
    @(negedge clk);
    s_valid = 1'b0; s_data = ~d; bipolar = ~b; hi_supply = ~h;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    @(negedge clk); #1;
  endtask

  task automatic check_write(input logic [11:0] exp, input logic b, input logic h);
    int wr_exp, cs_min, ds_min;
    wr_exp = h ? (240 + 3) / 4 : (400 + 3) / 4;
    cs_min = h ? (200 + 3) / 4 : (380 + 3) / 4;
    ds_min = h ? (120 + 3) / 4 : (210 + 3) / 4;
    if (b) chk(dac_db == exp, "R4 bipolar bus code", dac_db, exp);
    else   chk(dac_db == exp, "R3 unipolar bus code", dac_db, exp);
    chk(latch_q == exp, "R10 latched value", latch_q, exp);
    chk(last_wr == wr_exp, "R6 strobe width", last_wr, wr_exp);
    chk(last_cs >= cs_min, "R7 select lead", last_cs, cs_min);
    chk(last_ds >= ds_min, "R8 data setup", last_ds, ds_min);
    chk(last_pre >= 2, "R5 bus before select", last_pre, 2);
    chk(last_hold >= 3, "R9 hold cycles", last_hold, 3);
  endtask

  // {sample, bipolar, hi_supply, expected bus code}
  localparam logic [25:0] VEC [6] = '{
    {12'h000, 1'b0, 1'b0, 12'h000},
    {12'hFFF, 1'b0, 1'b1, 12'hFFF},
    {12'h7FF, 1'b1, 1'b0, 12'hFFF},
    {12'h800, 1'b1, 1'b1, 12'h000},
    {12'hA5C, 1'b0, 1'b1, 12'hA5C},
    {12'h123, 1'b1, 1'b0, 12'h923}
  };

  initial begin
    int w0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    #1;
    // R1: reset state and no spontaneous write
    chk(dac_cs_n == 1'b1, "R1 cs_n after reset", dac_cs_n, 1);
    chk(dac_wr_n == 1'b1, "R1 wr_n after reset", dac_wr_n, 1);
    chk(dac_db == 12'h000, "R1 bus after reset", dac_db, 0);
    chk(s_ready == 1'b1 && busy == 1'b0, "R1 idle flags", {s_ready, busy}, 2);
    chk(writes == 0, "R1 no write before sample", writes, 0);

    for (int i = 0; i < 6; i++) begin
      send(VEC[i][25:14], VEC[i][13], VEC[i][12]);
      #1;
      chk(busy == 1'b1 && s_ready == 1'b0, "R2 busy during write", {busy, s_ready}, 2);
      wait_idle();
      check_write(VEC[i][11:0], VEC[i][13], VEC[i][12]);
    end

    // R2: stall while busy, sample must not be dropped
    w0 = writes;
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1; s_data = 12'h3C4; bipolar = 1'b0; hi_supply = 1'b1;
    @(negedge clk);
    s_data = 12'h5E1; bipolar = 1'b1; hi_supply = 1'b0;
    repeat (10) @(negedge clk);
    chk(s_ready == 1'b0, "R2 ready low while stalled", s_ready, 0);
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    wait_idle();
    chk(writes == w0 + 2, "R2 stalled sample written", writes, w0 + 2);
    check_write(12'hDE1, 1'b1, 1'b0);

    chk(order_err == 0, "R5 strobe ordering", order_err, 0);
    chk(glitch_err == 0, "R8 bus frozen while open", glitch_err, 0);
    chk(hold_err == 0, "R9 bus held after strobe", hold_err, 0);
    chk(busy_err == 0, "R2 busy while selected", busy_err, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule